// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is one DMA channel. Software loads a control word, a peripheral-side address, a memory-side address and a beat count while the channel is off, then turns it on. Each time the request input is seen high while the channel is enabled and idle, the channel issues one read beat from the source and then one write beat to the destination on a simple memory-mapped master port. After every completed write the count goes down by one. When it reaches zero the channel stops and raises a done flag.

A single direction bit decides which attribute set feeds which side. Each set holds a size, an increment flag and an address. The same rule holds for every pairing of memories and peripherals. Data read from the source is taken from its byte lanes and resized to the destination size. It is then placed on the destination's byte lanes with matching byte strobes.

A bus error clears the enable and sets an error flag. The enable cannot be set again until software clears that flag. The master port is valid/ready. A beat is presented with `m_valid` high and its command and write data held stable until the cycle in which `m_ready` is high. The responder gives `m_rdata` and `m_err` in that same handshake cycle. The channel never withdraws a beat it has presented.

Top module: `dma_channel`

## Requirements
- R1: Control word fields: bit 0 enable, bit 1 direction, bits 3:2 peripheral size, bits 5:4 memory size, bit 6 peripheral increment, bit 7 memory increment. With direction 0 the read beat uses the peripheral size, increment and address, and the write beat uses the memory set. With direction 1 the two sets are swapped. `m_size` carries the size code of the beat's side.
- R2: Each accepted request gives exactly one read beat (`m_write`=0) and then one write beat (`m_write`=1). A beat stays valid with its command unchanged until `m_ready`. There is at least one idle cycle between a completed write and the next read.
- R3: After a completed beat, that side's address advances by 1, 2 or 4 for size codes 00, 01 and 10 if its increment bit is 1. Otherwise the address is unchanged.
- R4: The read value is `m_rdata` shifted right by 8 times the source address bits [1:0]. During a write, `m_strb` is the destination lane mask (0001, 0011 or 1111) shifted left by the destination address bits [1:0]. `m_wdata` holds the value shifted left by 8 times those bits. Strobe and data are zero outside writes.
- R5: A narrower source is zero-extended to the destination size. A wider source is truncated to the low bytes of the destination size.
- R6: `m_err` in a handshake cycle of either beat clears the enable and sets the error flag. No further beat is issued, and a failed write does not decrement the count.
- R7: While the error flag is set, a control write with the enable bit 1 leaves the channel disabled. Pulsing `err_clr` clears the flag, and the enable then works.
- R8: Size code 11 in either size field of an enabling control write sets the error flag and leaves the channel disabled, with no beat issued.
- R9: The 16-bit count decrements after each completed write beat. Reaching zero sets the done flag and clears the enable. Enabling with a count of zero sets the done flag at once without any beat. A successful enable clears the done flag.
- R10: Configuration writes (select 0 control, 1 peripheral address, 2 memory address, 3 count) take effect only while the channel is disabled. Writes made while it is enabled are ignored.
- R11: After reset the channel is disabled, both flags are clear and no beat is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 peripheral address, 2 memory address, 3 count |
| cfg_wdata | input | 32 | Configuration write data |
| err_clr | input | 1 | Write-one pulse clearing the error flag |
| dreq | input | 1 | Transfer request level |
| m_valid | output | 1 | Beat valid |
| m_ready | input | 1 | Beat accepted; response valid this cycle |
| m_write | output | 1 | 1 write beat, 0 read beat |
| m_addr | output | AW | Beat byte address |
| m_size | output | 2 | Beat size code |
| m_wdata | output | 32 | Write data, lane aligned |
| m_strb | output | 4 | Write byte strobes |
| m_rdata | input | 32 | Read data, valid in the read handshake |
| m_err | input | 1 | Bus error, valid in the handshake |
| ch_en | output | 1 | Channel enable |
| err_flag | output | 1 | Transfer error flag |
| done_flag | output | 1 | Transfer complete flag |

## Verification
A wrong sequencer state shows on `m_valid` or `m_write` in the very next cycle. A wrong address or attribute choice shows in `m_addr` and `m_size` on the next beat it affects. A fault in lane extraction or resizing appears on `m_wdata` and `m_strb` in the write beat that follows the read. A broken lockout or count shows on `ch_en`, `err_flag` or `done_flag` one cycle after the write, handshake or error that should have changed them. Comparing all outputs every cycle against a behavioural model therefore localises a fault to within one beat.

// File: rtl/dma_pkg.sv
package dma_pkg;
  localparam int DW = 32;
  localparam int LANES = DW / 8;
  localparam logic [1:0] SZ_RSVD = 2'b11;

  typedef enum logic [1:0] {BEAT_IDLE = 2'd0, BEAT_RD = 2'd1, BEAT_WR = 2'd2} beat_t;
  typedef enum logic [1:0] {SEL_CTRL = 2'd0, SEL_PADDR = 2'd1, SEL_MADDR = 2'd2, SEL_COUNT = 2'd3} cfg_sel_t;

  function automatic logic [2:0] sz_step(input logic [1:0] sz);
    case (sz)
      2'b00:   return 3'd1;
      2'b01:   return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [DW-1:0] sz_mask(input logic [1:0] sz);
    case (sz)
      2'b00:   return DW'(32'h0000_00FF);
      2'b01:   return DW'(32'h0000_FFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic [LANES-1:0] sz_lanes(input logic [1:0] sz);
    case (sz)
      2'b00:   return LANES'(4'b0001);
      2'b01:   return LANES'(4'b0011);
      default: return '1;
    endcase
  endfunction
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          err_clr,
  input  logic          src_adv,
  input  logic          dst_adv,
  input  logic          cnt_dec,
  input  logic          bus_err,
  output logic          en,
  output logic          terr,
  output logic          tcif,
  output logic [1:0]    src_sz,
  output logic [1:0]    dst_sz,
  output logic [AW-1:0] src_addr,
  output logic [AW-1:0] dst_addr
);
  logic          en_q, dir_q, pinc_q, minc_q, terr_q, tcif_q;
  logic [1:0]    psz_q, msz_q;
  logic [AW-1:0] par_q, mar_q;
  logic [CW-1:0] cnt_q;
  logic          cfg_ok, p_adv, m_adv;
  logic [1:0]    n_psz, n_msz;

  assign cfg_ok = cfg_wr & ~en_q;
  assign p_adv  = dir_q ? dst_adv : src_adv;
  assign m_adv  = dir_q ? src_adv : dst_adv;
  assign n_psz  = cfg_wdata[3:2];
  assign n_msz  = cfg_wdata[5:4];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q <= 1'b0; dir_q <= 1'b0; pinc_q <= 1'b0; minc_q <= 1'b0;
      terr_q <= 1'b0; tcif_q <= 1'b0; psz_q <= '0; msz_q <= '0;
      par_q <= '0; mar_q <= '0; cnt_q <= '0;
    end else begin
      if (p_adv && pinc_q) par_q <= par_q + AW'(sz_step(psz_q));
      if (m_adv && minc_q) mar_q <= mar_q + AW'(sz_step(msz_q));
      if (cnt_dec) begin
        cnt_q <= cnt_q - CW'(1);
        if (cnt_q == CW'(1)) begin
          en_q   <= 1'b0;
          tcif_q <= 1'b1;
        end
      end
      if (err_clr) terr_q <= 1'b0;
      if (bus_err) begin
        terr_q <= 1'b1;
        en_q   <= 1'b0;
      end
      if (cfg_ok) begin
        case (cfg_sel_t'(cfg_sel))
          SEL_CTRL: begin
            dir_q  <= cfg_wdata[1];
            psz_q  <= n_psz;
            msz_q  <= n_msz;
            pinc_q <= cfg_wdata[6];
            minc_q <= cfg_wdata[7];
            if (cfg_wdata[0] && !terr_q) begin
              if (n_psz == SZ_RSVD || n_msz == SZ_RSVD) terr_q <= 1'b1;
              else if (cnt_q == '0) tcif_q <= 1'b1;
              else begin
                en_q   <= 1'b1;
                tcif_q <= 1'b0;
              end
            end
          end
          SEL_PADDR: par_q <= cfg_wdata[AW-1:0];
          SEL_MADDR: mar_q <= cfg_wdata[AW-1:0];
          default:   cnt_q <= cfg_wdata[CW-1:0];
        endcase
      end
    end
  end

  assign en       = en_q;
  assign terr     = terr_q;
  assign tcif     = tcif_q;
  assign src_sz   = dir_q ? msz_q : psz_q;
  assign dst_sz   = dir_q ? psz_q : msz_q;
  assign src_addr = dir_q ? mar_q : par_q;
  assign dst_addr = dir_q ? par_q : mar_q;

  // R7: an error flag never coexists with a live enable
  a_r7_locked_out: assert property (@(posedge clk) disable iff (!rst_n)
    terr_q |-> !en_q);
  // R10: while enabled, addresses change only through beat advances
  a_r10_paddr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !p_adv) |=> $stable(par_q));
  a_r10_maddr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !m_adv) |=> $stable(mar_q));
  // R9: count moves only on completed writes while running; done drops enable
  a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !cnt_dec) |=> $stable(cnt_q));
  a_r9_done_stops: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tcif_q) |-> !en_q);
endmodule

// File: rtl/dma_beat_seq.sv
module dma_beat_seq
  import dma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dreq,
  input  logic          m_ready,
  input  logic          m_err,
  input  logic [DW-1:0] m_rdata,
  input  logic [1:0]    src_off,
  output logic          m_valid,
  output logic          m_write,
  output logic          src_adv,
  output logic          dst_adv,
  output logic          cnt_dec,
  output logic          bus_err,
  output logic [DW-1:0] raw_q,
  output logic [1:0]    off_q
);
  beat_t st_q;

  assign m_valid = (st_q != BEAT_IDLE);
  assign m_write = (st_q == BEAT_WR);
  assign bus_err = m_valid & m_ready & m_err;
  assign src_adv = (st_q == BEAT_RD) & m_ready & ~m_err;
  assign dst_adv = (st_q == BEAT_WR) & m_ready & ~m_err;
  assign cnt_dec = dst_adv;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= BEAT_IDLE;
      raw_q <= '0;
      off_q <= '0;
    end else begin
      case (st_q)
        BEAT_IDLE: if (en && dreq) st_q <= BEAT_RD;
        BEAT_RD: if (m_ready) begin
          if (m_err) st_q <= BEAT_IDLE;
          else begin
            raw_q <= m_rdata;
            off_q <= src_off;
            st_q  <= BEAT_WR;
          end
        end
        default: if (m_ready) st_q <= BEAT_IDLE;
      endcase
    end
  end

  // R2: a presented beat is held until accepted
  a_r2_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_write)));
  // R2: a good read is followed directly by its write
  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    src_adv |=> (m_valid && m_write));
  // R2: a finished write leaves one idle cycle
  a_r2_gap_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    dst_adv |=> !m_valid);
  // R6: an error ends bus activity
  a_r6_halt_on_error: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |=> !m_valid);
endmodule

// File: rtl/dma_lane_pack.sv
module dma_lane_pack
  import dma_pkg::*;
(
  input  logic [DW-1:0]    raw,
  input  logic [1:0]       src_off,
  input  logic [1:0]       src_sz,
  input  logic [1:0]       dst_off,
  input  logic [1:0]       dst_sz,
  output logic [DW-1:0]    wdata,
  output logic [LANES-1:0] strb
);
  logic [DW-1:0] val;
  logic [DW-1:0] lane_bits;

  assign val   = (raw >> {src_off, 3'b000}) & sz_mask(src_sz) & sz_mask(dst_sz);
  assign wdata = val << {dst_off, 3'b000};
  assign strb  = sz_lanes(dst_sz) << dst_off;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign lane_bits[8*b +: 8] = {8{strb[b]}};
  end

  // R4: no data bits outside strobed lanes
  always_comb begin
    a_r4_data_in_lanes: assert ((wdata & ~lane_bits) == '0);
  end
endmodule

// File: rtl/dma_channel.sv
module dma_channel
  import dma_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_wr,
  input  logic [1:0]    cfg_sel,
  input  logic [31:0]   cfg_wdata,
  input  logic          err_clr,
  input  logic          dreq,
  output logic          m_valid,
  input  logic          m_ready,
  output logic          m_write,
  output logic [AW-1:0] m_addr,
  output logic [1:0]    m_size,
  output logic [31:0]   m_wdata,
  output logic [3:0]    m_strb,
  input  logic [31:0]   m_rdata,
  input  logic          m_err,
  output logic          ch_en,
  output logic          err_flag,
  output logic          done_flag
);
  logic          src_adv, dst_adv, cnt_dec, bus_err;
  logic [1:0]    src_sz, dst_sz, off_q;
  logic [AW-1:0] src_addr, dst_addr;
  logic [DW-1:0] raw_q, pk_wdata;
  logic [3:0]    pk_strb;

  dma_chan_regs #(.AW(AW), .CW(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .err_clr(err_clr), .src_adv(src_adv),
    .dst_adv(dst_adv), .cnt_dec(cnt_dec), .bus_err(bus_err),
    .en(ch_en), .terr(err_flag), .tcif(done_flag), .src_sz(src_sz),
    .dst_sz(dst_sz), .src_addr(src_addr), .dst_addr(dst_addr)
  );

  dma_beat_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(ch_en), .dreq(dreq), .m_ready(m_ready),
    .m_err(m_err), .m_rdata(m_rdata), .src_off(src_addr[1:0]),
    .m_valid(m_valid), .m_write(m_write), .src_adv(src_adv),
    .dst_adv(dst_adv), .cnt_dec(cnt_dec), .bus_err(bus_err),
    .raw_q(raw_q), .off_q(off_q)
  );

  dma_lane_pack u_pack (
    .raw(raw_q), .src_off(off_q), .src_sz(src_sz),
    .dst_off(dst_addr[1:0]), .dst_sz(dst_sz),
    .wdata(pk_wdata), .strb(pk_strb)
  );

  assign m_addr  = m_write ? dst_addr : src_addr;
  assign m_size  = m_write ? dst_sz : src_sz;
  assign m_wdata = m_write ? pk_wdata : '0;
  assign m_strb  = m_write ? pk_strb : '0;

  // R1: the size code never changes within a held beat
  a_r1_size_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> $stable(m_size));
  // R8: a disabled channel presents no beat
  a_r8_no_beat_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_en && !m_valid) |=> !m_valid);
endmodule

// File: tb/sim_dma_channel.sv
module sim_dma_channel;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, cfg_wr = 1'b0, err_clr = 1'b0, dreq = 1'b0;
  logic [1:0]  cfg_sel = 2'd0;
  logic [31:0] cfg_wdata = '0, m_rdata = '0;
  logic        m_ready = 1'b0, m_err = 1'b0;
  logic        m_valid, m_write, ch_en, err_flag, done_flag;
  logic [31:0] m_addr, m_wdata;
  logic [1:0]  m_size;
  logic [3:0]  m_strb;

  dma_channel u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .err_clr(err_clr), .dreq(dreq),
    .m_valid(m_valid), .m_ready(m_ready), .m_write(m_write),
    .m_addr(m_addr), .m_size(m_size), .m_wdata(m_wdata), .m_strb(m_strb),
    .m_rdata(m_rdata), .m_err(m_err), .ch_en(ch_en),
    .err_flag(err_flag), .done_flag(done_flag)
  );

  int checks = 0, errors = 0, cyc = 0;
  int st = 0;
  bit e_en, e_terr, e_tcif, e_dir, e_pinc, e_minc, en0, terr0;
  bit [1:0] e_psz, e_msz, e_off, s_sz, d_sz;
  bit [31:0] e_par, e_mar, e_raw, s_a, d_a, x_val;
  bit [15:0] e_cnt;
  bit rdy_all = 1'b1, err_arm = 1'b0;
  int err_state = 2;
  bit [31:0] rng = 32'h1234_5679;

  function automatic bit [31:0] mk(bit [1:0] s);
    return (s == 2'd0) ? 32'hFF : (s == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction
  function automatic bit [3:0] lanes(bit [1:0] s);
    return (s == 2'd0) ? 4'b0001 : (s == 2'd1) ? 4'b0011 : 4'b1111;
  endfunction
  function automatic bit [31:0] ctrl(bit en, bit dir, bit [1:0] psz, bit [1:0] msz, bit pinc, bit minc);
    return {24'd0, minc, pinc, msz, psz, dir, en};
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // behavioural reference, advanced on each rising edge
  always @(posedge clk) begin
    if (!rst_n) begin
      st = 0; e_en = 0; e_terr = 0; e_tcif = 0; e_dir = 0; e_pinc = 0; e_minc = 0;
      e_psz = 0; e_msz = 0; e_par = 0; e_mar = 0; e_cnt = 0; e_raw = 0; e_off = 0;
    end else begin
      en0 = e_en; terr0 = e_terr;
      s_a = e_dir ? e_mar : e_par;
      if (err_clr) e_terr = 0;
      if (st == 0) begin
        if (en0 && dreq) st = 1;
      end else if (m_ready && m_err) begin
        e_terr = 1; e_en = 0; st = 0;
      end else if (m_ready && st == 1) begin
        e_raw = m_rdata; e_off = s_a[1:0];
        if (!e_dir && e_pinc) e_par += 32'(1 << e_psz);
        if (e_dir && e_minc) e_mar += 32'(1 << e_msz);
        st = 2;
      end else if (m_ready && st == 2) begin
        if (!e_dir && e_minc) e_mar += 32'(1 << e_msz);
        if (e_dir && e_pinc) e_par += 32'(1 << e_psz);
        e_cnt--;
        if (e_cnt == 0) begin e_tcif = 1; e_en = 0; end
        st = 0;
      end
      if (cfg_wr && !en0) begin
        case (cfg_sel)
          2'd0: begin
            e_dir = cfg_wdata[1]; e_psz = cfg_wdata[3:2]; e_msz = cfg_wdata[5:4];
            e_pinc = cfg_wdata[6]; e_minc = cfg_wdata[7];
            if (cfg_wdata[0] && !terr0) begin
              if (e_psz == 3 || e_msz == 3) e_terr = 1;
              else if (e_cnt == 0) e_tcif = 1;
              else begin e_en = 1; e_tcif = 0; end
            end
          end
          2'd1: e_par = cfg_wdata;
          2'd2: e_mar = cfg_wdata;
          default: e_cnt = cfg_wdata[15:0];
        endcase
      end
    end
  end

  // compare every cycle, then drive the responder
  always @(negedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
    if (rst_n) begin
      s_a = e_dir ? e_mar : e_par; d_a = e_dir ? e_par : e_mar;
      s_sz = e_dir ? e_msz : e_psz; d_sz = e_dir ? e_psz : e_msz;
      x_val = (e_raw >> (8 * e_off)) & mk(s_sz) & mk(d_sz);
      chk("R2", "m_valid", m_valid, 32'(st != 0));
      chk("R2", "m_write", m_write, 32'(st == 2));
      chk("R3", "m_addr", m_addr, (st == 2) ? d_a : s_a);
      chk("R1", "m_size", m_size, (st == 2) ? d_sz : s_sz);
      chk("R5", "m_wdata", m_wdata, (st == 2) ? (x_val << (8 * d_a[1:0])) : 32'd0);
      chk("R4", "m_strb", m_strb, (st == 2) ? 32'((lanes(d_sz) << d_a[1:0]) & 4'hF) : 32'd0);
      chk("R7", "ch_en", ch_en, 32'(e_en));
      chk("R6", "err_flag", err_flag, 32'(e_terr));
      chk("R9", "done_flag", done_flag, 32'(e_tcif));
    end
    rng ^= rng << 13; rng ^= rng >> 17; rng ^= rng << 5;
    m_rdata <= rng;
    m_ready <= rdy_all | rng[3] | rng[7];
    m_err <= 1'b0;
    if (err_arm && st == err_state && (rdy_all | rng[3] | rng[7])) begin
      m_err <= 1'b1;
      err_arm = 1'b0;
    end
  end

  task automatic cfg(bit [1:0] sel, bit [31:0] d);
    @(negedge clk); cfg_wr = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk); cfg_wr = 0;
  endtask
  task automatic pulse_clr();
    @(negedge clk); err_clr = 1;
    @(negedge clk); err_clr = 0;
  endtask
  task automatic wait_off();
    for (int i = 0; i < 4000 && ch_en; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11", "reset en", ch_en, 0);
    chk("R11", "reset flags", {err_flag, done_flag}, 0);
    chk("R11", "reset valid", m_valid, 0);
    rst_n = 1;
    // dir 0: 32-bit peripheral source, byte memory destination, truncation
    cfg(1, 32'h0000_0100); cfg(2, 32'h0000_0203); cfg(3, 3);
    dreq = 1; cfg(0, ctrl(1, 0, 2, 0, 0, 1));
    wait_off();
    chk("R9", "done after count", {done_flag, ch_en}, 32'b10);
    // dir 1: byte memory source at odd offset, 32-bit incrementing peripheral, random ready
    rdy_all = 0;
    cfg(1, 32'h0000_0400); cfg(2, 32'h0000_0801); cfg(3, 4);
    cfg(0, ctrl(1, 1, 2, 0, 1, 1));
    wait_off();
    // R10: writes while enabled are ignored
    dreq = 0;
    cfg(1, 32'h0000_1002); cfg(2, 32'h0000_2000); cfg(3, 2);
    cfg(0, ctrl(1, 0, 1, 1, 1, 1));
    cfg(1, 32'h0000_5550); cfg(3, 9);
    dreq = 1;
    for (int i = 0; i < 20 && !m_valid; i++) @(negedge clk);
    chk("R10", "address after ignored write", m_addr, 32'h0000_1002);
    wait_off();
    // R6: error on a write beat
    err_arm = 1; err_state = 2;
    cfg(3, 5); cfg(0, ctrl(1, 1, 0, 1, 0, 1));
    wait_off();
    chk("R6", "error flag", {err_flag, ch_en}, 32'b10);
    // R7: enable locked until the flag is cleared
    cfg(0, ctrl(1, 0, 0, 0, 1, 1));
    chk("R7", "locked enable", ch_en, 0);
    pulse_clr();
    chk("R7", "flag cleared", err_flag, 0);
    // R6: error on a read beat
    err_arm = 1; err_state = 1;
    cfg(0, ctrl(1, 0, 0, 0, 1, 1));
    chk("R7", "enable after clear", ch_en, 1);
    wait_off();
    chk("R6", "read error stops", {err_flag, ch_en}, 32'b10);
    pulse_clr();
    // R8: reserved size code
    cfg(0, ctrl(1, 0, 3, 0, 0, 0));
    chk("R8", "reserved peripheral size", {err_flag, ch_en}, 32'b10);
    pulse_clr();
    cfg(0, ctrl(1, 1, 0, 3, 0, 0));
    repeat (3) @(negedge clk);
    chk("R8", "reserved memory size, no beat", {err_flag, ch_en, m_valid}, 32'b100);
    pulse_clr();
    // R9: enable with a zero count
    cfg(3, 0); cfg(0, ctrl(1, 0, 1, 2, 1, 0));
    chk("R9", "zero count", {done_flag, ch_en}, 32'b10);
    // mixed 16-bit to 32-bit, zero extension, random ready
    cfg(1, 32'h0000_3002); cfg(2, 32'h0000_4000); cfg(3, 6);
    cfg(0, ctrl(1, 0, 1, 2, 1, 1));
    chk("R9", "done cleared on enable", {done_flag, ch_en}, 32'b01);
    wait_off();
    chk("R5", "widening run complete", {done_flag, err_flag}, 32'b10);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule